// File: doc/BRIEF.md
# MSI Capability Register File

This block holds the Message Signalled Interrupt capability structure of a PCI function inside its configuration space. A configuration bus decoder (outside the block) presents dword-aligned offsets relative to the capability base, together with four byte enables; writes land on the clock edge and reads return the addressed bytes combinationally. The header and message control word are built at reset from parameters that give the number of vectors, whether 64-bit message addresses are supported, and the pointer to the next capability.

Besides the header, the block stores the message address, message data, per-vector mask and per-vector pending registers. Their current values are driven out to a neighbouring message generator. That generator records held vectors through set and clear inputs on the pending register. When software clears a mask bit while MSI is enabled, the block raises a one-cycle unmask pulse for that vector, so the generator can send any message it was holding.

Top module: `msi_cap_regfile`

## Requirements
- R1: After reset, dword 0 reads as {message control high byte 0x01, message control low byte, next pointer parameter, 0x05}. The low byte has MSI Enable (bit 0) at 0, the vector capability code in bits 3:1, bits 6:4 at 0, and the 64-bit flag in bit 7. All other registers read zero.
- R2: Writes to byte 0 (capability ID) and byte 1 (next pointer) of dword 0 have no effect.
- R3: A write to byte 2 (message control low) stores data bits 0, 4, 5 and 6 and keeps bits 1, 2, 3 and 7 at their current value.
- R4: Writes to byte 3 (message control high: per-vector masking flag in bit 8, zero in bits 15:9) have no effect, so it always reads 0x01.
- R5: A write changes only the byte lanes whose enable is set. A read returns zero in lanes whose enable is clear.
- R6: The vector capability code is the smallest n in 0..5 with 2^n at least the vector count parameter. A count outside 1..32 is rejected at elaboration.
- R7: With 64-bit support, dwords 1..5 hold address low, address high, data (bits 15:0 only), mask and pending. Without it, dwords 1..4 hold address, data, mask and pending. Any other offset, or any offset with bits 1:0 non-zero, reads zero and ignores writes.
- R8: Mask and pending registers reset to zero.
- R9: In the cycle after a mask write that takes effect, unmask_pulse bit (lane*8 + bit) is 1 exactly when that mask bit went from 1 to 0 while MSI Enable was 1. All its bits are zero in every other cycle.
- R10: The next pending value is ((value after any config write) AND NOT pend_clr) OR pend_set, so a set wins over a clear.
- R11: msi_enable is control bit 0, mme is control bits 6:4, msg_data is the data register, and msg_addr is {address high, address low}, or {zero, address} without 64-bit support.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_off | input | 8 | Byte offset from capability base (dword aligned) |
| cfg_be | input | 4 | Byte lane enables for read and write |
| cfg_wdata | input | 32 | Write data, lane 0 in bits 7:0 |
| cfg_rdata | output | 32 | Combinational read data |
| pend_set | input | 32 | Per-vector pending set from the generator |
| pend_clr | input | 32 | Per-vector pending clear from the generator |
| msi_enable | output | 1 | MSI Enable control bit |
| mme | output | 3 | Multiple Message Enable field |
| msg_addr | output | 64 | Message address |
| msg_data | output | 16 | Message data |
| mask_bits | output | 32 | Per-vector mask register |
| pend_bits | output | 32 | Per-vector pending register |
| unmask_pulse | output | 32 | One-cycle pulse per vector whose mask fell while enabled |

## Verification
The bound assertions check on every cycle that an unmask pulse only follows a write made while MSI was enabled and only marks bits whose mask really fell. They also check that control and mask hold still without a write, and that the pending set and clear inputs take effect. Only the bench scenarios can show the exact field values. These include the header and capability code for two layouts, the protection of each control bit over every possible written byte, the placement of each register in both layouts, and the exact pulse vector over a wide sweep of old and new mask bytes in every lane.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;

    localparam logic [7:0] CAP_ID_MSI = 8'h05;
    localparam int         MAX_VEC    = 32;

    // Smallest n (0..5) such that 2**n covers the vector count.
    function automatic logic [2:0] mmc_of(input int count);
        logic [2:0] n;
        n = 3'd5;
        for (int i = 5; i >= 0; i--) begin
            if ((1 << i) >= count) n = 3'(i);
        end
        return n;
    endfunction

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_HDR,
        SEL_ADDR_LO,
        SEL_ADDR_HI,
        SEL_DATA,
        SEL_MASK,
        SEL_PEND
    } reg_sel_e;

    typedef struct packed {
        logic [7:0]  ctrl_lo;
        logic [31:0] addr_lo;
        logic [31:0] addr_hi;
        logic [31:0] data;
        logic [31:0] mask;
        logic [31:0] pend;
        logic [31:0] unmask;
    } cap_state_t;

endpackage

// File: rtl/msi_cap_decode.sv
module msi_cap_decode
    import msi_cap_pkg::*;
#(
    parameter bit ADDR64 = 1'b1
) (
    input  logic [7:0] off,
    output reg_sel_e   sel
);
    localparam logic [5:0] DW_HDR     = 6'd0;
    localparam logic [5:0] DW_ADDR_LO = 6'd1;
    localparam logic [5:0] DW_ADDR_HI = 6'd2;
    localparam logic [5:0] DW_DATA    = ADDR64 ? 6'd3 : 6'd2;
    localparam logic [5:0] DW_MASK    = ADDR64 ? 6'd4 : 6'd3;
    localparam logic [5:0] DW_PEND    = ADDR64 ? 6'd5 : 6'd4;

    logic [5:0] dw;
    assign dw = off[7:2];

    always_comb begin
        sel = SEL_NONE;
        if (off[1:0] == 2'b00) begin
            if (dw == DW_HDR)                    sel = SEL_HDR;
            else if (dw == DW_ADDR_LO)           sel = SEL_ADDR_LO;
            else if (ADDR64 && dw == DW_ADDR_HI) sel = SEL_ADDR_HI;
            else if (dw == DW_DATA)              sel = SEL_DATA;
            else if (dw == DW_MASK)              sel = SEL_MASK;
            else if (dw == DW_PEND)              sel = SEL_PEND;
        end
    end
endmodule

// File: rtl/msi_cap_lane_merge.sv
module msi_cap_lane_merge #(
    parameter int LANES = 4,
    localparam int W    = LANES * 8
) (
    input  logic             en,
    input  logic [LANES-1:0] be,
    input  logic [W-1:0]     wdata,
    input  logic [W-1:0]     old,
    output logic [W-1:0]     merged
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign merged[l*8 +: 8] = (en && be[l]) ? wdata[l*8 +: 8] : old[l*8 +: 8];
    end
endmodule

// File: rtl/msi_cap_unmask_detect.sv
module msi_cap_unmask_detect #(
    parameter int N = 32
) (
    input  logic         arm,
    input  logic [N-1:0] old_mask,
    input  logic [N-1:0] new_mask,
    output logic [N-1:0] fell
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        assign fell[i] = arm && old_mask[i] && !new_mask[i];
    end
endmodule

// File: rtl/msi_cap_regfile.sv
module msi_cap_regfile
    import msi_cap_pkg::*;
#(
    parameter int         VEC_COUNT = 4,
    parameter bit         ADDR64    = 1'b1,
    parameter logic [7:0] NEXT_PTR  = 8'h00
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr,
    input  logic [7:0]  cfg_off,
    input  logic [3:0]  cfg_be,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic [31:0] pend_set,
    input  logic [31:0] pend_clr,
    output logic        msi_enable,
    output logic [2:0]  mme,
    output logic [63:0] msg_addr,
    output logic [15:0] msg_data,
    output logic [31:0] mask_bits,
    output logic [31:0] pend_bits,
    output logic [31:0] unmask_pulse
);
    localparam logic [2:0] MMC      = mmc_of(VEC_COUNT);
    localparam logic [7:0] CTRL_RO  = 8'h8E;
    localparam logic [7:0] CTRL_RST = {ADDR64, 3'b000, MMC, 1'b0};
    localparam logic [7:0] CTRL_HI  = 8'h01;
    localparam cap_state_t ST_RST   = '{
        ctrl_lo: CTRL_RST,
        addr_lo: 32'h0,
        addr_hi: 32'h0,
        data:    32'h0,
        mask:    32'h0,
        pend:    32'h0,
        unmask:  32'h0
    };

    if (VEC_COUNT < 1 || VEC_COUNT > MAX_VEC) begin : g_bad_cfg
        $error("msi_cap_regfile: VEC_COUNT out of range");
    end

    cap_state_t st_d, st_q;
    reg_sel_e   sel;

    logic [31:0] m_addr_lo, m_addr_hi, m_data, m_mask, m_pend, fell;

    msi_cap_decode #(.ADDR64(ADDR64)) u_dec (
        .off (cfg_off),
        .sel (sel)
    );

    msi_cap_lane_merge #(.LANES(4)) u_m_alo (
        .en(cfg_wr && sel == SEL_ADDR_LO), .be(cfg_be), .wdata(cfg_wdata),
        .old(st_q.addr_lo), .merged(m_addr_lo)
    );
    msi_cap_lane_merge #(.LANES(4)) u_m_ahi (
        .en(cfg_wr && sel == SEL_ADDR_HI), .be(cfg_be), .wdata(cfg_wdata),
        .old(st_q.addr_hi), .merged(m_addr_hi)
    );
    msi_cap_lane_merge #(.LANES(4)) u_m_data (
        .en(cfg_wr && sel == SEL_DATA), .be(cfg_be), .wdata(cfg_wdata),
        .old(st_q.data), .merged(m_data)
    );
    msi_cap_lane_merge #(.LANES(4)) u_m_mask (
        .en(cfg_wr && sel == SEL_MASK), .be(cfg_be), .wdata(cfg_wdata),
        .old(st_q.mask), .merged(m_mask)
    );
    msi_cap_lane_merge #(.LANES(4)) u_m_pend (
        .en(cfg_wr && sel == SEL_PEND), .be(cfg_be), .wdata(cfg_wdata),
        .old(st_q.pend), .merged(m_pend)
    );

    msi_cap_unmask_detect #(.N(32)) u_unmask (
        .arm      (cfg_wr && sel == SEL_MASK && st_q.ctrl_lo[0]),
        .old_mask (st_q.mask),
        .new_mask (m_mask),
        .fell     (fell)
    );

    // Next-state computation
    always_comb begin
        st_d = st_q;
        if (cfg_wr && sel == SEL_HDR && cfg_be[2]) begin
            st_d.ctrl_lo = (cfg_wdata[23:16] & ~CTRL_RO) | (st_q.ctrl_lo & CTRL_RO);
        end
        st_d.addr_lo = m_addr_lo;
        st_d.addr_hi = ADDR64 ? m_addr_hi : 32'h0;
        st_d.data    = m_data & 32'h0000_FFFF;
        st_d.mask    = m_mask;
        st_d.pend    = (m_pend & ~pend_clr) | pend_set;
        st_d.unmask  = fell;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_RST;
        else        st_q <= st_d;
    end

    // Combinational read path
    logic [31:0] rd_dw, lane_mask;
    always_comb begin
        case (sel)
            SEL_HDR:     rd_dw = {CTRL_HI, st_q.ctrl_lo, NEXT_PTR, CAP_ID_MSI};
            SEL_ADDR_LO: rd_dw = st_q.addr_lo;
            SEL_ADDR_HI: rd_dw = st_q.addr_hi;
            SEL_DATA:    rd_dw = st_q.data;
            SEL_MASK:    rd_dw = st_q.mask;
            SEL_PEND:    rd_dw = st_q.pend;
            default:     rd_dw = 32'h0;
        endcase
        lane_mask = {{8{cfg_be[3]}}, {8{cfg_be[2]}}, {8{cfg_be[1]}}, {8{cfg_be[0]}}};
        cfg_rdata = rd_dw & lane_mask;
    end

    assign msi_enable   = st_q.ctrl_lo[0];
    assign mme          = st_q.ctrl_lo[6:4];
    assign msg_addr     = {st_q.addr_hi, st_q.addr_lo};
    assign msg_data     = st_q.data[15:0];
    assign mask_bits    = st_q.mask;
    assign pend_bits    = st_q.pend;
    assign unmask_pulse = st_q.unmask;
endmodule

// File: rtl/msi_cap_checker.sv
module msi_cap_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_wr,
    input logic [31:0] pend_set,
    input logic [31:0] pend_clr,
    input logic        msi_enable,
    input logic [2:0]  mme,
    input logic [31:0] mask_bits,
    input logic [31:0] pend_bits,
    input logic [31:0] unmask_pulse
);
    AST_PULSE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (|unmask_pulse)) |-> $past(cfg_wr)); // R9

    AST_PULSE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (|unmask_pulse)) |-> $past(msi_enable)); // R9

    AST_PULSE_MASK_FELL: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (|unmask_pulse)) |->
        (((unmask_pulse & mask_bits) == 32'h0) && ((unmask_pulse & ~$past(mask_bits)) == 32'h0))); // R9

    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(cfg_wr)) |-> ($stable(msi_enable) && $stable(mme))); // R3

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(cfg_wr)) |-> $stable(mask_bits)); // R5

    AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (($past(pend_set) & ~pend_bits) == 32'h0)); // R10

    AST_PEND_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (($past(pend_clr) & ~$past(pend_set) & pend_bits) == 32'h0)); // R10
endmodule

bind msi_cap_regfile msi_cap_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_wr       (cfg_wr),
    .pend_set     (pend_set),
    .pend_clr     (pend_clr),
    .msi_enable   (msi_enable),
    .mme          (mme),
    .mask_bits    (mask_bits),
    .pend_bits    (pend_bits),
    .unmask_pulse (unmask_pulse)
);

// File: tb/sim_msi_cap_regfile.sv
module sim_msi_cap_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_off = 8'h0;
    logic [3:0]  cfg_be = 4'h0;
    logic [31:0] cfg_wdata = 32'h0;
    logic [31:0] pend_set = 32'h0;
    logic [31:0] pend_clr = 32'h0;

    logic [31:0] rdata0, rdata1;
    logic        en0, en1;
    logic [2:0]  mme0, mme1;
    logic [63:0] addr0, addr1;
    logic [15:0] data0, data1;
    logic [31:0] mask0, mask1, pend0, pend1, pulse0, pulse1;

    always #2 clk = ~clk;

    msi_cap_regfile #(.VEC_COUNT(4), .ADDR64(1'b1), .NEXT_PTR(8'h48)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_off(cfg_off), .cfg_be(cfg_be),
        .cfg_wdata(cfg_wdata), .cfg_rdata(rdata0), .pend_set(pend_set), .pend_clr(pend_clr),
        .msi_enable(en0), .mme(mme0), .msg_addr(addr0), .msg_data(data0),
        .mask_bits(mask0), .pend_bits(pend0), .unmask_pulse(pulse0)
    );

    msi_cap_regfile #(.VEC_COUNT(32), .ADDR64(1'b0), .NEXT_PTR(8'h00)) u1 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_off(cfg_off), .cfg_be(cfg_be),
        .cfg_wdata(cfg_wdata), .cfg_rdata(rdata1), .pend_set(pend_set), .pend_clr(pend_clr),
        .msi_enable(en1), .mme(mme1), .msg_addr(addr1), .msg_data(data1),
        .mask_bits(mask1), .pend_bits(pend1), .unmask_pulse(pulse1)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] off, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_off = off; cfg_be = be; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] off, input logic [3:0] be,
                      output logic [31:0] r0, output logic [31:0] r1);
        @(negedge clk);
        cfg_off = off; cfg_be = be;
        #1;
        r0 = rdata0; r1 = rdata1;
    endtask

    function automatic logic [2:0] exp_mmc(input int cnt);
        for (int n = 0; n < 6; n++) if ((1 << n) >= cnt) return 3'(n);
        return 3'd7;
    endfunction

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] r0, r1;
        logic [7:0]  c0_rst, c1_rst, exp_c;
        c0_rst = {1'b1, 3'b000, exp_mmc(4), 1'b0};
        c1_rst = {1'b0, 3'b000, exp_mmc(32), 1'b0};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 / R6 / R8: reset contents in both layouts
        rd(8'h00, 4'hF, r0, r1);
        chk("R1 hdr 64b", {32'h0, r0}, {32'h0, 8'h01, c0_rst, 8'h48, 8'h05});
        chk("R1 hdr 32b", {32'h0, r1}, {32'h0, 8'h01, c1_rst, 8'h00, 8'h05});
        chk("R6 mmc count4", {61'h0, r0[19:17]}, 64'd2);
        chk("R6 mmc count32", {61'h0, r1[19:17]}, 64'd5);
        for (int k = 1; k < 7; k++) begin
            rd(8'(k * 4), 4'hF, r0, r1);
            chk("R8 reset zero u0", {32'h0, r0}, 64'h0);
            chk("R8 reset zero u1", {32'h0, r1}, 64'h0);
        end
        chk("R11 reset enable", {63'h0, en0}, 64'h0);

        // R2 / R3 / R4 / R11: every byte into control, header protected
        for (int v = 0; v < 256; v++) begin
            wr(8'h00, 4'hF, {8'(v) ^ 8'h5A, 8'(v), 8'(v) ^ 8'hFF, 8'(v)});
            exp_c = (8'(v) & 8'h71) | (c0_rst & 8'h8E);
            rd(8'h00, 4'hF, r0, r1);
            chk("R2 R3 R4 hdr after write", {32'h0, r0}, {32'h0, 8'h01, exp_c, 8'h48, 8'h05});
            chk("R11 enable/mme", {60'h0, en0, mme0}, {60'h0, exp_c[0], exp_c[6:4]});
        end
        wr(8'h00, 4'h4, 32'h0);

        // R7 / R11: layout in both configurations
        for (int k = 1; k < 7; k++) wr(8'(k * 4), 4'hF, 32'h1111_1111 * k);
        rd(8'h04, 4'hF, r0, r1);
        chk("R7 u0 addr lo", {32'h0, r0}, 64'h1111_1111);
        chk("R7 u1 addr", {32'h0, r1}, 64'h1111_1111);
        rd(8'h08, 4'hF, r0, r1);
        chk("R7 u0 addr hi", {32'h0, r0}, 64'h2222_2222);
        chk("R7 u1 data", {32'h0, r1}, 64'h0000_2222);
        rd(8'h0C, 4'hF, r0, r1);
        chk("R7 u0 data", {32'h0, r0}, 64'h0000_3333);
        chk("R7 u1 mask", {32'h0, r1}, 64'h3333_3333);
        rd(8'h10, 4'hF, r0, r1);
        chk("R7 u0 mask", {32'h0, r0}, 64'h4444_4444);
        chk("R7 u1 pend", {32'h0, r1}, 64'h4444_4444);
        rd(8'h14, 4'hF, r0, r1);
        chk("R7 u0 pend", {32'h0, r0}, 64'h5555_5555);
        chk("R7 u1 beyond", {32'h0, r1}, 64'h0);
        rd(8'h18, 4'hF, r0, r1);
        chk("R7 u0 beyond", {32'h0, r0}, 64'h0);
        rd(8'h05, 4'hF, r0, r1);
        chk("R7 misaligned read", {32'h0, r0}, 64'h0);
        wr(8'h05, 4'hF, 32'hFFFF_FFFF);
        rd(8'h04, 4'hF, r0, r1);
        chk("R7 misaligned write ignored", {32'h0, r0}, 64'h1111_1111);
        chk("R11 u0 msg_addr", addr0, 64'h2222_2222_1111_1111);
        chk("R11 u1 msg_addr", addr1, 64'h0000_0000_1111_1111);
        chk("R11 u0 msg_data", {48'h0, data0}, 64'h3333);
        chk("R11 u1 msg_data", {48'h0, data1}, 64'h2222);

        // R5: byte enables on write and read
        wr(8'h04, 4'b0101, 32'hAABB_CCDD);
        rd(8'h04, 4'hF, r0, r1);
        chk("R5 partial write", {32'h0, r0}, 64'h11BB_11DD);
        rd(8'h04, 4'b0010, r0, r1);
        chk("R5 partial read", {32'h0, r0}, 64'h0000_1100);

        // R9: unmask pulses with enable off
        wr(8'h10, 4'hF, 32'hFFFF_FFFF);
        wr(8'h10, 4'hF, 32'h0);
        chk("R9 no pulse when disabled", {32'h0, pulse0}, 64'h0);

        // R9: sweep with enable on (control bit 0)
        wr(8'h00, 4'h4, 32'h0001_0000);
        for (int lane = 0; lane < 4; lane++) begin
            int so, sn;
            so = (lane == 0) ? 3 : 37;
            sn = (lane == 0) ? 7 : 29;
            for (int o = 0; o < 256; o += so) begin
                for (int n = 0; n < 256; n += sn) begin
                    logic [31:0] ex;
                    wr(8'h10, 4'hF, 32'(o) << (8 * lane));
                    wr(8'h10, 4'(1 << lane), 32'(n) << (8 * lane));
                    ex = (32'(o) & ~32'(n) & 32'hFF) << (8 * lane);
                    chk("R9 pulse vector", {32'h0, pulse0}, {32'h0, ex});
                    chk("R9 mask stored", {32'h0, mask0}, {32'h0, 32'(n) << (8 * lane)});
                    @(negedge clk);
                    chk("R9 pulse one cycle", {32'h0, pulse0}, 64'h0);
                end
            end
        end
        wr(8'h10, 4'hF, 32'h0);

        // R10: pending set/clear from the generator
        wr(8'h14, 4'hF, 32'h0);
        @(negedge clk); pend_set = 32'h0000_00F0;
        @(negedge clk); pend_set = 32'h0;
        chk("R10 set", {32'h0, pend0}, 64'hF0);
        rd(8'h14, 4'hF, r0, r1);
        chk("R10 readback", {32'h0, r0}, 64'hF0);
        @(negedge clk); pend_clr = 32'h0000_0030;
        @(negedge clk); pend_clr = 32'h0;
        chk("R10 clear", {32'h0, pend0}, 64'hC0);
        @(negedge clk); pend_set = 32'h30; pend_clr = 32'h30;
        @(negedge clk); pend_set = 32'h0; pend_clr = 32'h0;
        chk("R10 set beats clear", {32'h0, pend0}, 64'hF0);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_off = 8'h14; cfg_be = 4'hF; cfg_wdata = 32'hFFFF_0000;
        pend_clr = 32'h0001_0000; pend_set = 32'h0000_0001;
        @(negedge clk);
        cfg_wr = 1'b0; pend_clr = 32'h0; pend_set = 32'h0;
        chk("R10 write with set/clear", {32'h0, pend0}, 64'hFFFE_0001);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule